// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a small register stage, four bits wide by default, whose two-bit mode input picks one of four actions on every rising clock edge. It can keep its contents, move every bit one place toward the higher index, move every bit one place toward the lower index, or take a whole new word from its parallel inputs. The stored word is always visible on the parallel outputs.

Each side has its own serial input. When the register moves toward the higher index, the low-side serial input fills stage 0. When it moves toward the lower index, the high-side serial input fills the top stage. The end stages of the parallel output also serve as the serial outputs. Stage 0 is the output for moves toward the lower index, and the top stage is the output for moves toward the higher index. Because of this, identical units can be wired end to end to form a wider register.

An active-low master clear empties the register as soon as it is asserted, without waiting for the clock. It overrides every mode.

Top module: `bidir_shift_reg`

## Requirements
- R1: Driving `rstN` low clears every stage of `parOut` to 0 at once, with no clock edge needed.
- R2: While `rstN` is low, rising clock edges leave `parOut` at 0 in every mode, including parallel load with nonzero data.
- R3: With `modeSel` = 2'b00 (keep), `parOut` stays unchanged across any number of rising edges, whatever the data and serial inputs are.
- R4: With `modeSel` = 2'b01 (move up), each rising edge sets stage i to the old stage i-1 for i ≥ 1, and sets stage 0 to `serRightIn`.
- R5: With `modeSel` = 2'b10 (move down), each rising edge sets stage i to the old stage i+1 for i < WIDTH-1, and sets the top stage to `serLeftIn`.
- R6: With `modeSel` = 2'b11 (load), each rising edge copies `parIn` into `parOut`.
- R7: Changes on `modeSel`, `parIn`, `serRightIn` or `serLeftIn` between rising edges do not change `parOut`.
- R8: Two units, with the top stage of the lower unit feeding `serRightIn` of the upper unit and stage 0 of the upper unit feeding `serLeftIn` of the lower unit, behave as one register of twice the width in all four modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all mode actions take place on its rising edge |
| rstN | input | 1 | Asynchronous master clear, active low |
| modeSel | input | 2 | Mode: 00 keep, 01 move up, 10 move down, 11 load |
| parIn | input | WIDTH | Parallel data, copied in load mode |
| serRightIn | input | 1 | Serial data that enters stage 0 when moving up |
| serLeftIn | input | 1 | Serial data that enters the top stage when moving down |
| parOut | output | WIDTH | Stored word; stage 0 and the top stage double as the serial outputs |

## Verification
The bench uses the default WIDTH of 4 for a standalone unit. It also uses WIDTH of 4 for two more units chained into an 8-bit register, so both the end-stage boundaries and the hand-off across the chain seam are reached with few edges. A narrow width lets a walking pattern run from one end to the other and out again within a handful of cycles. The master clear is also asserted in the middle of a cycle, away from any edge, to show that it acts without the clock.

// File: rtl/bidir_shift_pkg.sv
package bidir_shift_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shiftMode_e;

  typedef struct packed {
    logic loadEn;
    logic moveUp;
    logic moveDown;
  } shiftStrobes_t;

endpackage

// File: rtl/bidir_shift_ctrl.sv
module bidir_shift_ctrl
  import bidir_shift_pkg::*;
(
  input  logic [1:0]    modeSel,
  output shiftStrobes_t strobes
);

  shiftMode_e mode;

  always_comb begin
    mode    = shiftMode_e'(modeSel);
    strobes = '0;
    unique case (mode)
      MODE_UP:   strobes.moveUp   = 1'b1;
      MODE_DOWN: strobes.moveDown = 1'b1;
      MODE_LOAD: strobes.loadEn   = 1'b1;
      default:   strobes          = '0;
    endcase
  end

endmodule

// File: rtl/bidir_shift_datapath.sv
module bidir_shift_datapath
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobes_t    strobes,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serRightIn,
  input  logic             serLeftIn,
  output logic [WIDTH-1:0] stageQ
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] fromBelow;
  logic [WIDTH-1:0] fromAbove;
  logic [WIDTH-1:0] stageNext;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_low_end
      assign fromBelow[i] = serRightIn;
    end else begin : g_low_mid
      assign fromBelow[i] = stageQ[i-1];
    end

    if (i == TOP) begin : g_high_end
      assign fromAbove[i] = serLeftIn;
    end else begin : g_high_mid
      assign fromAbove[i] = stageQ[i+1];
    end

    always_comb begin
      if (strobes.loadEn)        stageNext[i] = parIn[i];
      else if (strobes.moveUp)   stageNext[i] = fromBelow[i];
      else if (strobes.moveDown) stageNext[i] = fromAbove[i];
      else                       stageNext[i] = stageQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= stageNext;
  end

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serRightIn,
  input  logic             serLeftIn,
  output logic [WIDTH-1:0] parOut
);

  shiftStrobes_t strobes;

  bidir_shift_ctrl u_ctrl (
    .modeSel (modeSel),
    .strobes (strobes)
  );

  bidir_shift_datapath #(.WIDTH(WIDTH)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .parIn      (parIn),
    .serRightIn (serRightIn),
    .serLeftIn  (serLeftIn),
    .stageQ     (parOut)
  );

endmodule

// File: rtl/bidir_shift_reg_checker.sv
module bidir_shift_reg_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeSel,
  input logic [WIDTH-1:0] parIn,
  input logic             serRightIn,
  input logic             serLeftIn,
  input logic [WIDTH-1:0] parOut
);

  // R2: clear overrides every mode
  a_r2_clear_wins: assert property (@(posedge clk)
    !rstN |-> parOut == '0);

  a_r3_keep: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeSel) == 2'b00) |-> $stable(parOut));

  a_r4_move_up: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeSel) == 2'b01)
      |-> parOut == {$past(parOut[WIDTH-2:0]), $past(serRightIn)});

  a_r5_move_down: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeSel) == 2'b10)
      |-> parOut == {$past(serLeftIn), $past(parOut[WIDTH-1:1])});

  a_r6_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeSel) == 2'b11) |-> parOut == $past(parIn));

endmodule

bind bidir_shift_reg bidir_shift_reg_checker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .parIn      (parIn),
  .serRightIn (serRightIn),
  .serLeftIn  (serLeftIn),
  .parOut     (parOut)
);

// File: tb/test_bidir_shift_reg.sv
module test_bidir_shift_reg;

  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] modeSel;
  logic [W-1:0] parIn;
  logic serRightIn, serLeftIn;
  logic [W-1:0] parOut;

  logic [2*W-1:0] wideIn;
  logic [W-1:0] lowOut, highOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) i_bidir_shift_reg (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .parIn(parIn),
    .serRightIn(serRightIn), .serLeftIn(serLeftIn), .parOut(parOut)
  );

  // R8: two units chained into one wide register
  bidir_shift_reg #(.WIDTH(W)) i_low (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .parIn(wideIn[W-1:0]),
    .serRightIn(serRightIn), .serLeftIn(highOut[0]), .parOut(lowOut)
  );
  bidir_shift_reg #(.WIDTH(W)) i_high (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .parIn(wideIn[2*W-1:W]),
    .serRightIn(lowOut[W-1]), .serLeftIn(serLeftIn), .parOut(highOut)
  );

  // reference models: queue index 0 is stage 0
  bit refQ[$];
  bit wideQ[$];

  function automatic logic [15:0] toVec(bit q[$]);
    logic [15:0] v = '0;
    foreach (q[k]) v[k] = q[k];
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (refQ[k]) refQ[k] = 0;
      foreach (wideQ[k]) wideQ[k] = 0;
    end else begin
      case (modeSel)
        2'b01: begin
          refQ.push_front(serRightIn);  void'(refQ.pop_back());
          wideQ.push_front(serRightIn); void'(wideQ.pop_back());
        end
        2'b10: begin
          refQ.push_back(serLeftIn);  void'(refQ.pop_front());
          wideQ.push_back(serLeftIn); void'(wideQ.pop_front());
        end
        2'b11: begin
          foreach (refQ[k]) refQ[k] = parIn[k];
          foreach (wideQ[k]) wideQ[k] = wideIn[k];
        end
        default: ;
      endcase
    end
  end

  task automatic compare(input string req);
    logic [15:0] expNarrow = toVec(refQ);
    logic [15:0] expWide = toVec(wideQ);
    checks++;
    if (parOut !== expNarrow[W-1:0]) begin
      errors++;
      $display("FAIL %s narrow actual %b expected %b", req, parOut, expNarrow[W-1:0]);
    end
    checks++;
    if ({highOut, lowOut} !== expWide[2*W-1:0]) begin
      errors++;
      $display("FAIL %s wide actual %b expected %b", req, {highOut, lowOut}, expWide[2*W-1:0]);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] p,
                      input logic [2*W-1:0] wp, input logic sr, input logic sl,
                      input string req);
    modeSel = m; parIn = p; wideIn = wp; serRightIn = sr; serLeftIn = sl;
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    for (int k = 0; k < W; k++) refQ.push_back(0);
    for (int k = 0; k < 2*W; k++) wideQ.push_back(0);
    rstN = 1'b0; modeSel = 2'b11; parIn = '1; wideIn = '1;
    serRightIn = 1'b1; serLeftIn = 1'b1;
    repeat (3) @(negedge clk);
    compare("R2 reset state under load");
    rstN = 1'b1;

    // R6 load, several patterns
    step(2'b11, 4'b1010, 8'hC5, 0, 0, "R6 load");
    step(2'b11, 4'b0110, 8'h3A, 1, 1, "R6 load");
    // R3 keep with busy inputs
    for (int k = 0; k < 4; k++)
      step(2'b00, 4'(k * 5), 8'(k * 37), k[0], ~k[0], "R3 keep");
    // R4 move up, walking a one through and out of the top
    step(2'b11, 4'b0000, 8'h00, 0, 0, "R6 load zero");
    step(2'b01, 4'hF, 8'hFF, 1, 0, "R4 move up");
    for (int k = 0; k < 2*W; k++)
      step(2'b01, 4'(k), 8'(k), 0, 1, "R4 R8 move up walk");
    // R5 move down, walking a one the other way
    step(2'b10, 4'h0, 8'h00, 0, 1, "R5 move down");
    for (int k = 0; k < 2*W; k++)
      step(2'b10, 4'(k), 8'(k), 1, 0, "R5 R8 move down walk");
    // mixed pattern across the chain seam
    step(2'b11, 4'b1001, 8'b1000_0001, 0, 0, "R8 load");
    step(2'b01, 4'h0, 8'h00, 1, 0, "R8 move up");
    step(2'b10, 4'h0, 8'h00, 0, 1, "R8 move down");
    step(2'b10, 4'h0, 8'h00, 1, 0, "R8 move down");

    // R7: inputs change between edges, output holds
    step(2'b11, 4'b0101, 8'h5A, 0, 0, "R6 load");
    modeSel = 2'b11; parIn = 4'b1111; wideIn = 8'hFF;
    #(CLK_PERIOD/4);
    modeSel = 2'b01; serRightIn = 1'b1;
    #(CLK_PERIOD/8);
    compare("R7 no change between edges");

    // R1: asynchronous clear mid-cycle
    @(negedge clk);
    step(2'b11, 4'b1111, 8'hFF, 0, 0, "R6 load ones");
    #(CLK_PERIOD/4);
    rstN = 1'b0;
    #1;
    compare("R1 async clear");
    // R2: edges during clear in every mode
    for (int m = 0; m < 4; m++)
      step(2'(m), 4'hF, 8'hFF, 1, 1, "R2 clear wins");
    rstN = 1'b1;
    step(2'b11, 4'b0011, 8'h81, 0, 0, "R6 load after clear");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule